// File: doc/BRIEF.md
# Mailbox Interrupt Status Controller

This block sits between a host link and a local processor. The host side deposits 32-bit words into eight mailbox slots. Each deposit raises a per-slot flag in an interrupt status word. The local processor reads the slots through its own register port and cannot change them. Two further status flags record that a link write or a link read failed. The link logic reports these failures as single-cycle pulses.

The local processor reads the status word and clears flags by writing ones. The host can also clear the two failure flags through its own clear register. An enable word selects which status flags drive the interrupt line. Only positions backed by a real status flag can hold a 1. The interrupt line is a registered level. It is high while any flag and its enable are both set.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, the status word, the enable word, every mailbox slot and `irq_o` are all 0.
- R2: A host write to byte address 0x0B00 + 4*i (i = 0..7) stores `h_wdata` in slot i. From the next cycle, a local read of address 0x3B20 + 4*i returns it. A later write to the same slot replaces the value.
- R3: A host write to slot i sets status bit 16+i in the status word. The local port reads the status word at address 0x3060.
- R4: A pulse on `link_wr_fail` sets status bit 0, and a pulse on `link_rd_fail` sets status bit 1.
- R5: A local write to 0x3060 clears every status bit where `l_wdata` is 1. Bits written as 0 keep their value, and a status bit never becomes 1 without its set event.
- R6: A host write to address 0x0040 clears status bits 0 and 1 where `h_wdata` is 1. It leaves bits 16..23 unchanged.
- R7: Status bits 2..15 and 24..31 always read as 0. A local read of an address that maps to no register (including a misaligned slot address) returns 0.
- R8: A local write to 0x3070 loads the enable word masked to bits 0, 1 and 16..23. Ones written elsewhere are dropped, and the enable word reads back at 0x3070.
- R9: `irq_o` equals, one cycle late, the OR over all bits of status AND enable. It rises the cycle after a flag and its enable are both 1, and it falls the cycle after that no longer holds.
- R10: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up 1.
- R11: Local writes to the mailbox addresses 0x3B20 + 4*i change neither the slots nor the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| link_wr_fail | input | 1 | One-cycle pulse: a link write failed |
| link_rd_fail | input | 1 | One-cycle pulse: a link read failed |
| h_wr_en | input | 1 | Host register write strobe |
| h_addr | input | 14 | Host register byte address |
| h_wdata | input | 32 | Host write data |
| l_wr_en | input | 1 | Local register write strobe |
| l_addr | input | 14 | Local register byte address (write and read) |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, combinational from `l_addr` |
| irq_o | output | 1 | Registered level interrupt to the local processor |

## Verification
The hardest case to reach from the ports is a set event and a clear arriving on the same flag in the same cycle. The bench drives a failure pulse together with a local write-one-to-clear of that bit in one cycle. It then drives a host slot deposit together with a local clear of that slot's flag, also in one cycle. The one-cycle lag of the interrupt is swept flag by flag. For each flag the bench sets it, enables it alone, and samples `irq_o` at both the cycle before and the cycle after the expected edge, on the way up and on the way down.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  localparam int unsigned REG_W       = 32;
  localparam int unsigned WR_FAIL_POS = 0;
  localparam int unsigned RD_FAIL_POS = 1;
  localparam int unsigned MBOX_POS_LO = 16;
  localparam int unsigned MBOX_MAX    = 8;

  typedef logic [REG_W-1:0] reg_word_t;

  // Positions of the status word that carry a real flag.
  function automatic reg_word_t impl_mask(input int unsigned n_mbox);
    reg_word_t m;
    m = '0;
    m[WR_FAIL_POS] = 1'b1;
    m[RD_FAIL_POS] = 1'b1;
    for (int unsigned k = 0; k < MBOX_MAX; k++) begin
      if (k < n_mbox) m[MBOX_POS_LO + k] = 1'b1;
    end
    return m;
  endfunction

  // Positions the host clear register may touch.
  function automatic reg_word_t fail_mask();
    reg_word_t m;
    m = '0;
    m[WR_FAIL_POS] = 1'b1;
    m[RD_FAIL_POS] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/mbx_data_regs.sv
module mbx_data_regs
  import mbx_irq_pkg::*;
#(
  parameter  int unsigned NUM_MBOX = 8,
  localparam int unsigned IDX_W    = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MBOX-1:0] wr_hit,
  input  reg_word_t           wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output reg_word_t           rd_data
);

  logic [NUM_MBOX-1:0][REG_W-1:0] slot_vec;

  for (genvar g = 0; g < NUM_MBOX; g++) begin : g_slot
    reg_word_t slot_d;
    reg_word_t slot_q;

    always_comb begin
      slot_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_hit[g]) begin
        slot_q <= slot_d;
      end
    end

    assign slot_vec[g] = slot_q;
  end

  always_comb begin
    rd_data = slot_vec[rd_idx];
  end

endmodule

// File: rtl/mbx_status_reg.sv
module mbx_status_reg
  import mbx_irq_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  reg_word_t set_vec,
  input  reg_word_t clr_vec,
  output reg_word_t sts_q
);

  localparam reg_word_t IMPL = impl_mask(NUM_MBOX);

  reg_word_t sts_d;
  logic      sts_ce;

  // Clear is applied first, so a set in the same cycle survives.
  always_comb begin
    sts_d  = ((sts_q & ~clr_vec) | set_vec) & IMPL;
    sts_ce = |((set_vec | clr_vec) & IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_ce) begin
      sts_q <= sts_d;
    end
  end

endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
  import mbx_irq_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_we,
  input  reg_word_t en_wdata,
  input  reg_word_t sts,
  output reg_word_t en_q,
  output logic      irq_o
);

  localparam reg_word_t IMPL = impl_mask(NUM_MBOX);

  reg_word_t en_d;
  logic      irq_d;
  logic      irq_q;

  always_comb begin
    en_d  = en_wdata & IMPL;
    irq_d = |(sts & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned       NUM_MBOX        = 8,
  parameter int unsigned       ADDR_W          = 14,
  parameter logic [ADDR_W-1:0] LOC_STATUS_ADDR = 14'h3060,
  parameter logic [ADDR_W-1:0] LOC_ENABLE_ADDR = 14'h3070,
  parameter logic [ADDR_W-1:0] LOC_MBX_BASE    = 14'h3B20,
  parameter logic [ADDR_W-1:0] HOST_MBX_BASE   = 14'h0B00,
  parameter logic [ADDR_W-1:0] HOST_CLR_ADDR   = 14'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_wr_fail,
  input  logic              link_rd_fail,
  input  logic              h_wr_en,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [REG_W-1:0]  h_wdata,
  input  logic              l_wr_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [REG_W-1:0]  l_wdata,
  output logic [REG_W-1:0]  l_rdata,
  output logic              irq_o
);

  localparam int unsigned       IDX_W    = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;
  localparam logic [ADDR_W-1:0] MBX_SPAN = ADDR_W'(4 * NUM_MBOX);
  localparam reg_word_t         HCLR_M   = fail_mask();

  logic [NUM_MBOX-1:0] mbx_hit;
  logic                host_clr_we;
  logic                loc_sts_we;
  logic                loc_en_we;
  logic [ADDR_W-1:0]   l_off;
  logic                l_mbx_sel;
  logic [IDX_W-1:0]    rd_idx;
  reg_word_t           mbx_rd;
  reg_word_t           sts_set;
  reg_word_t           sts_clr;
  reg_word_t           sts_q;
  reg_word_t           en_q;

  // Host-side decode: one strobe per mailbox slot.
  for (genvar g = 0; g < NUM_MBOX; g++) begin : g_hdec
    localparam logic [ADDR_W-1:0] SLOT_A = HOST_MBX_BASE + ADDR_W'(4 * g);
    assign mbx_hit[g] = h_wr_en && (h_addr == SLOT_A);
  end

  assign host_clr_we = h_wr_en && (h_addr == HOST_CLR_ADDR);
  assign loc_sts_we  = l_wr_en && (l_addr == LOC_STATUS_ADDR);
  assign loc_en_we   = l_wr_en && (l_addr == LOC_ENABLE_ADDR);

  // Local-side slot window: aligned words inside the mailbox span.
  always_comb begin
    l_off     = l_addr - LOC_MBX_BASE;
    l_mbx_sel = (l_addr >= LOC_MBX_BASE) && (l_off < MBX_SPAN) && (l_addr[1:0] == 2'b00);
    rd_idx    = l_off[IDX_W+1:2];
  end

  always_comb begin
    sts_set = '0;
    sts_set[WR_FAIL_POS] = link_wr_fail;
    sts_set[RD_FAIL_POS] = link_rd_fail;
    sts_set[MBOX_POS_LO +: NUM_MBOX] = mbx_hit;
    sts_clr = '0;
    if (loc_sts_we)  sts_clr = sts_clr | l_wdata;
    if (host_clr_we) sts_clr = sts_clr | (h_wdata & HCLR_M);
  end

  mbx_data_regs #(.NUM_MBOX(NUM_MBOX)) data_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (mbx_hit),
    .wr_data (h_wdata),
    .rd_idx  (rd_idx),
    .rd_data (mbx_rd)
  );

  mbx_status_reg #(.NUM_MBOX(NUM_MBOX)) status_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (sts_set),
    .clr_vec (sts_clr),
    .sts_q   (sts_q)
  );

  mbx_irq_gen #(.NUM_MBOX(NUM_MBOX)) irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (loc_en_we),
    .en_wdata (l_wdata),
    .sts      (sts_q),
    .en_q     (en_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    l_rdata = '0;
    if (l_addr == LOC_STATUS_ADDR) begin
      l_rdata = sts_q;
    end else if (l_addr == LOC_ENABLE_ADDR) begin
      l_rdata = en_q;
    end else if (l_mbx_sel) begin
      l_rdata = mbx_rd;
    end
  end

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk
  import mbx_irq_pkg::*;
#(
  parameter int unsigned       NUM_MBOX        = 8,
  parameter int unsigned       ADDR_W          = 14,
  parameter logic [ADDR_W-1:0] LOC_STATUS_ADDR = 14'h3060,
  parameter logic [ADDR_W-1:0] LOC_ENABLE_ADDR = 14'h3070
) (
  input logic                clk,
  input logic                rst_n,
  input logic                link_wr_fail,
  input logic                link_rd_fail,
  input logic                l_wr_en,
  input logic [ADDR_W-1:0]   l_addr,
  input logic [REG_W-1:0]    l_wdata,
  input logic [REG_W-1:0]    l_rdata,
  input logic                irq_o,
  input logic [NUM_MBOX-1:0] mbx_hit,
  input logic [REG_W-1:0]    sts_clr,
  input logic [REG_W-1:0]    sts_q,
  input logic [REG_W-1:0]    en_q
);

  localparam reg_word_t IMPL = impl_mask(NUM_MBOX);

  p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mbx_hit));

  p_mbx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mbx_hit) |=> ((sts_q[MBOX_POS_LO +: NUM_MBOX] & $past(mbx_hit)) == $past(mbx_hit)));

  p_rd_fail_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_rd_fail |=> sts_q[RD_FAIL_POS]);

  // Set beats a same-cycle clear (R10).
  p_wr_fail_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_wr_fail |=> sts_q[WR_FAIL_POS]);

  p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_wr_fail && !link_rd_fail && !(|mbx_hit)) |=> ((sts_q & ~$past(sts_q)) == '0));

  p_wr_fail_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr[WR_FAIL_POS] && !link_wr_fail) |=> !sts_q[WR_FAIL_POS]);

  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (l_addr == LOC_STATUS_ADDR) |-> ((l_rdata & ~IMPL) == '0));

  p_en_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr_en && (l_addr == LOC_ENABLE_ADDR)) |=> (en_q == ($past(l_wdata) & IMPL)));

  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|($past(sts_q) & $past(en_q))));

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(
  .NUM_MBOX        (NUM_MBOX),
  .ADDR_W          (ADDR_W),
  .LOC_STATUS_ADDR (LOC_STATUS_ADDR),
  .LOC_ENABLE_ADDR (LOC_ENABLE_ADDR)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_wr_fail (link_wr_fail),
  .link_rd_fail (link_rd_fail),
  .l_wr_en      (l_wr_en),
  .l_addr       (l_addr),
  .l_wdata      (l_wdata),
  .l_rdata      (l_rdata),
  .irq_o        (irq_o),
  .mbx_hit      (mbx_hit),
  .sts_clr      (sts_clr),
  .sts_q        (sts_q),
  .en_q         (en_q)
);

// File: tb/mbx_irq_ctrl_tb_top.sv
module mbx_irq_ctrl_tb_top;

  localparam int          NMB  = 8;
  localparam logic [13:0] STS  = 14'h3060;
  localparam logic [13:0] EN   = 14'h3070;
  localparam logic [13:0] LMB  = 14'h3B20;
  localparam logic [13:0] HMB  = 14'h0B00;
  localparam logic [13:0] HCLR = 14'h0040;
  localparam logic [31:0] IMPL = 32'h00FF_0003;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        link_wr_fail, link_rd_fail;
  logic        h_wr_en, l_wr_en;
  logic [13:0] h_addr, l_addr;
  logic [31:0] h_wdata, l_wdata, l_rdata;
  logic        irq_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] e_sts, e_en, p_set, p_clr, p_en;
  logic        p_en_we, e_irq;
  logic [31:0] e_mbx [NMB];

  mbx_irq_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_wr_fail (link_wr_fail),
    .link_rd_fail (link_rd_fail),
    .h_wr_en      (h_wr_en),
    .h_addr       (h_addr),
    .h_wdata      (h_wdata),
    .l_wr_en      (l_wr_en),
    .l_addr       (l_addr),
    .l_wdata      (l_wdata),
    .l_rdata      (l_rdata),
    .irq_o        (irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [13:0] a, input logic [31:0] exp, input string req);
    l_addr = a;
    #1;
    chk(l_rdata === exp, req, l_rdata, exp);
  endtask

  task automatic irq_chk(input string req);
    chk(irq_o === e_irq, req, {31'd0, irq_o}, {31'd0, e_irq});
  endtask

  task automatic idle();
    h_wr_en = 1'b0; l_wr_en = 1'b0;
    link_wr_fail = 1'b0; link_rd_fail = 1'b0;
  endtask

  task automatic d_host(input logic [13:0] a, input logic [31:0] d);
    h_wr_en = 1'b1; h_addr = a; h_wdata = d;
    for (int i = 0; i < NMB; i++) begin
      if (a == HMB + 14'(4 * i)) begin
        e_mbx[i] = d;
        p_set[16 + i] = 1'b1;
      end
    end
    if (a == HCLR) p_clr = p_clr | (d & 32'h3);
  endtask

  task automatic d_loc(input logic [13:0] a, input logic [31:0] d);
    l_wr_en = 1'b1; l_addr = a; l_wdata = d;
    if (a == STS) p_clr = p_clr | d;
    if (a == EN) begin p_en_we = 1'b1; p_en = d & IMPL; end
  endtask

  task automatic d_fail(input bit w, input bit r);
    link_wr_fail = w; link_rd_fail = r;
    p_set[0] = p_set[0] | w;
    p_set[1] = p_set[1] | r;
  endtask

  // One clock: the model moves with the design; irq follows the old state.
  task automatic cyc();
    @(negedge clk);
    idle();
    e_irq = |(e_sts & e_en);
    e_sts = ((e_sts & ~p_clr) | p_set) & IMPL;
    if (p_en_we) e_en = p_en;
    p_set = '0; p_clr = '0; p_en = '0; p_en_we = 1'b0;
  endtask

  task automatic rd_all_mbx(input string req);
    for (int i = 0; i < NMB; i++) rd_chk(LMB + 14'(4 * i), e_mbx[i], req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    h_addr = '0; h_wdata = '0; l_addr = '0; l_wdata = '0;
    e_sts = '0; e_en = '0; e_irq = 1'b0;
    p_set = '0; p_clr = '0; p_en = '0; p_en_we = 1'b0;
    for (int i = 0; i < NMB; i++) e_mbx[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    irq_chk("R1 irq after reset");
    rd_chk(STS, 32'h0, "R1 status after reset");
    rd_chk(EN, 32'h0, "R1 enable after reset");
    rd_all_mbx("R1 mailbox after reset");

    // R8: walk a single 1 across every enable position, then all ones
    for (int b = 0; b < 32; b++) begin
      d_loc(EN, 32'h1 << b); cyc();
      rd_chk(EN, (32'h1 << b) & IMPL, "R8 enable walk");
    end
    d_loc(EN, 32'hFFFF_FFFF); cyc();
    rd_chk(EN, IMPL, "R8 enable all ones");
    d_loc(EN, 32'h0); cyc(); cyc();

    // R2, R3: deposit into each slot; flags accumulate
    for (int i = 0; i < NMB; i++) begin
      d_host(HMB + 14'(4 * i), 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101)); cyc();
      rd_chk(LMB + 14'(4 * i), e_mbx[i], "R2 slot readback");
      rd_chk(STS, e_sts, "R3 status accumulates");
    end
    rd_all_mbx("R2 all slots");
    for (int i = 0; i < NMB; i++) begin
      d_host(HMB + 14'(4 * i), ~(32'h0F0F_0000 + 32'(i))); cyc();
    end
    rd_all_mbx("R2 overwrite");

    // R11: local writes into the slot window are ignored
    for (int i = 0; i < NMB; i++) begin
      d_loc(LMB + 14'(4 * i), 32'hDEAD_0000 + 32'(i)); cyc();
    end
    rd_all_mbx("R11 slots unchanged");
    rd_chk(STS, e_sts, "R11 status unchanged");

    // R5: zeros do nothing, ones clear one flag at a time
    d_loc(STS, 32'h0); cyc();
    rd_chk(STS, 32'h00FF_0000, "R5 write zero no effect");
    for (int i = 0; i < NMB; i++) begin
      d_loc(STS, 32'h1 << (16 + i)); cyc();
      rd_chk(STS, e_sts, "R5 clear one flag");
    end

    // R4: failure pulses
    d_fail(1'b1, 1'b0); cyc();
    rd_chk(STS, 32'h1, "R4 write failure flag");
    d_fail(1'b0, 1'b1); cyc();
    rd_chk(STS, 32'h3, "R4 read failure flag");

    // R6: host clear touches only bits 0 and 1
    d_host(HMB, 32'h55); cyc();
    d_host(HCLR, 32'h0); cyc();
    rd_chk(STS, 32'h0001_0003, "R6 host zero no effect");
    d_host(HCLR, 32'hFFFF_FFFE); cyc();
    rd_chk(STS, 32'h0001_0001, "R6 host clears read failure only");
    d_host(HCLR, 32'hFFFF_FFFF); cyc();
    rd_chk(STS, 32'h0001_0000, "R6 host keeps mailbox flag");
    d_loc(STS, 32'h0001_0000); cyc();
    rd_chk(STS, 32'h0, "R5 local clears mailbox flag");

    // R10: set and clear on the same bit in one cycle
    d_fail(1'b1, 1'b0); d_loc(STS, 32'h1); cyc();
    rd_chk(STS, 32'h1, "R10 failure set beats local clear");
    d_fail(1'b0, 1'b1); d_host(HCLR, 32'h2); cyc();
    rd_chk(STS, 32'h3, "R10 failure set beats host clear");
    d_host(HMB + 14'd12, 32'hCAFE_F00D); d_loc(STS, 32'h0008_0003); cyc();
    rd_chk(STS, 32'h0008_0000, "R10 deposit beats clear");
    d_loc(STS, 32'hFFFF_FFFF); cyc();

    // R7: reserved bits and unmapped addresses read as 0
    d_fail(1'b1, 1'b1); d_host(HMB + 14'd28, 32'h1); cyc();
    rd_chk(STS, 32'h0080_0003, "R7 reserved status bits zero");
    rd_chk(14'h3064, 32'h0, "R7 unmapped address");
    rd_chk(LMB + 14'(4 * NMB), 32'h0, "R7 beyond slot window");
    rd_chk(LMB + 14'd1, 32'h0, "R7 misaligned slot address");
    d_loc(STS, 32'hFFFF_FFFF); cyc(); cyc();

    // R9: per-flag interrupt sweep with one-cycle lag both ways
    for (int b = 0; b < 32; b++) begin
      if (IMPL[b]) begin
        if (b == 0) d_fail(1'b1, 1'b0);
        else if (b == 1) d_fail(1'b0, 1'b1);
        else d_host(HMB + 14'(4 * (b - 16)), 32'(b));
        cyc(); irq_chk("R9 flag set, not enabled");
        d_loc(EN, 32'h1 << b); cyc(); irq_chk("R9 no irq in enable cycle");
        cyc(); irq_chk("R9 irq rises one cycle late");
        chk(irq_o === 1'b1, "R9 irq high", {31'd0, irq_o}, 32'h1);
        d_loc(STS, 32'h1 << b); cyc(); irq_chk("R9 irq held in clear cycle");
        cyc(); irq_chk("R9 irq falls one cycle late");
        chk(irq_o === 1'b0, "R9 irq low", {31'd0, irq_o}, 32'h0);
        d_loc(EN, 32'h0); cyc();
      end
    end
    d_loc(EN, 32'hFFFF_FFFF); cyc(); cyc();
    irq_chk("R9 enables alone raise nothing");
    d_fail(1'b0, 1'b1); cyc(); cyc();
    irq_chk("R9 any enabled flag raises irq");
    d_loc(EN, 32'h0); cyc(); cyc();
    irq_chk("R9 disabling drops irq");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule